// File: doc/BRIEF.md
# Host Command Packet Handler

This block sits behind a host link that has already split the traffic into command packets. Each packet arrives one byte per cycle, with a start marker on its first byte and an end marker on its last. The block decodes the packet by its leading type byte. It can answer a discovery request with the unit's identity, store a board identifier that the host assigns, or apply a set of output values. The output values appear on a parallel bus together with a one-cycle update strobe.

An output/configuration command also carries a report rate in hertz. From that command on, the block sends data reports at that rate. Each report is a frame holding the board identifier and a snapshot of the channel inputs taken at the moment the frame begins. The rate timer works by accumulating the rate once per clock against the clock frequency, so no divider is needed. Every configuration command restarts the timer. Replies leave on a byte-wide stream with start and end markers, and a reply that has begun always runs to its end without a break.

Top module: `host_cmd_handler`

## Requirements
- R1: After reset the board identifier is 0, `out_vals` is 0, `upd_strobe` is low, no reply is sent and no reports run.
- R2: A packet whose byte 0 is 0 (discovery, any length) produces an 8-byte reply: byte 0 = 0, byte 1 = board identifier, bytes 2..7 = `STATION_MAC` most significant byte first. `out_sop` is on the first byte, `out_eop` is on the last, and `out_valid` stays high in between.
- R3: A packet with byte 0 = 1 and at least 2 bytes sets the board identifier to byte 1. It sends no reply.
- R4: A packet with byte 0 = 2 and at least 3 bytes is a configuration command. Payload bytes from index 3 onward go to output byte k = `out_vals[8k+7:8k]` for k < OUT_BYTES. Bytes beyond OUT_BYTES are ignored, and output bytes not carried keep their previous value. All new values appear in the single cycle in which `upd_strobe` is high.
- R5: After a configuration command, report frames are sent: byte 0 = 1, byte 1 = board identifier, then IN_BYTES snapshot bytes with byte 2+k = `in_snap[8k+7:8k]`. Consecutive reports that are not delayed start CLK_HZ/rate cycles apart.
- R6: The rate is byte 2 of the configuration command. A value of 0 acts as 1 Hz, and a value above 64 acts as 64 Hz.
- R7: A configuration command restarts the report timer. The first report begins CLK_HZ/rate + 2 cycles after the cycle in which the command's last byte is accepted.
- R8: No reply is broken off. A report that falls due while another reply is being sent starts within two cycles after that reply's final byte. A new start marker never appears inside a frame.
- R9: A packet with any other type value causes no reply, no strobe and no change to the board identifier.
- R10: A set-identifier packet shorter than 2 bytes and a configuration packet shorter than 3 bytes are dropped. Bytes that arrive without a preceding start marker, outside a packet, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_sop | input | 1 | First byte of a command packet |
| in_eop | input | 1 | Last byte of a command packet |
| in_data | input | 8 | Command byte |
| in_snap | input | 8*IN_BYTES | Live channel input data, sampled at report start |
| out_valid | output | 1 | Reply byte present |
| out_sop | output | 1 | First byte of a reply |
| out_eop | output | 1 | Last byte of a reply |
| out_data | output | 8 | Reply byte |
| out_vals | output | 8*OUT_BYTES | Applied output values |
| upd_strobe | output | 1 | One-cycle pulse when `out_vals` takes new values |

## Verification
The hardest situation to reach is a report falling due in the middle of a discovery reply, because the timer phase cannot be seen at the ports. The bench uses a rate whose period divides the clock exactly. It records the cycle in which a report starts, then sends a one-byte discovery packet timed so that its 8-byte reply covers the next due point. It then checks that the ping reply is intact and that the delayed report starts right after it. The restart rule is checked the same way, by timing each configuration command just after a report begins and measuring to the next start marker.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;

  typedef enum logic [7:0] {
    PT_PING  = 8'd0,
    PT_SETID = 8'd1,
    PT_CFG   = 8'd2
  } cmd_type_e;

  typedef enum logic [7:0] {
    RT_PING = 8'd0,
    RT_DATA = 8'd1
  } reply_type_e;

  localparam int unsigned RATE_MAX  = 64;
  localparam int unsigned RATE_W    = 7;
  localparam int unsigned PING_LEN  = 8;

  function automatic logic [RATE_W-1:0] clamp_rate(input logic [7:0] raw);
    if (raw == 8'd0)
      return RATE_W'(1);
    else if (raw > 8'(RATE_MAX))
      return RATE_W'(RATE_MAX);
    else
      return raw[RATE_W-1:0];
  endfunction

endpackage

// File: rtl/cmd_rx_parse.sv
module cmd_rx_parse
  import host_cmd_pkg::*;
#(
  parameter int unsigned OUT_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [7:0]               in_data,
  output logic                     ping_req,
  output logic                     set_req,
  output logic                     cfg_req,
  output logic [7:0]               cmd_id,
  output logic [RATE_W-1:0]        cmd_rate,
  output logic [OUT_BYTES*8-1:0]   payload
);

  localparam int unsigned IDX_MAX = OUT_BYTES + 3;
  localparam int unsigned IW      = $clog2(IDX_MAX + 1);

  logic                   in_pkt_q, in_pkt_d;
  logic [IW-1:0]          idx_q, idx_d, pos;
  logic [7:0]             typ_q, typ_d, id_q, id_d, rraw_q, rraw_d;
  logic [7:0]             cur_typ, cur_id, cur_rate;
  logic [OUT_BYTES*8-1:0] shadow_q, shadow_d;
  logic                   ping_q, ping_d, set_q, set_d, cfg_q, cfg_d;
  logic [7:0]             cid_q, cid_d;
  logic [RATE_W-1:0]      crate_q, crate_d;
  logic                   take;

  always_comb begin
    take     = in_valid && (in_sop || in_pkt_q);
    pos      = in_sop ? '0 : idx_q;
    cur_typ  = (pos == IW'(0)) ? in_data : typ_q;
    cur_id   = (pos == IW'(1)) ? in_data : id_q;
    cur_rate = (pos == IW'(2)) ? in_data : rraw_q;

    in_pkt_d = in_pkt_q;
    idx_d    = idx_q;
    typ_d    = typ_q;
    id_d     = id_q;
    rraw_d   = rraw_q;
    shadow_d = shadow_q;
    ping_d   = 1'b0;
    set_d    = 1'b0;
    cfg_d    = 1'b0;
    cid_d    = cid_q;
    crate_d  = crate_q;

    if (take) begin
      in_pkt_d = !in_eop;
      idx_d    = (pos == IW'(IDX_MAX)) ? pos : pos + IW'(1);
      if (pos == IW'(0)) typ_d  = in_data;
      if (pos == IW'(1)) id_d   = in_data;
      if (pos == IW'(2)) rraw_d = in_data;
      for (int b = 0; b < OUT_BYTES; b++) begin
        if (typ_q == PT_CFG && pos == IW'(b + 3))
          shadow_d[b*8 +: 8] = in_data;
      end
      if (in_eop) begin
        if (cur_typ == PT_PING) begin
          ping_d = 1'b1;
        end else if (cur_typ == PT_SETID && pos >= IW'(1)) begin
          set_d = 1'b1;
          cid_d = cur_id;
        end else if (cur_typ == PT_CFG && pos >= IW'(2)) begin
          cfg_d   = 1'b1;
          crate_d = clamp_rate(cur_rate);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      idx_q    <= '0;
      typ_q    <= '0;
      id_q     <= '0;
      rraw_q   <= '0;
      shadow_q <= '0;
      ping_q   <= 1'b0;
      set_q    <= 1'b0;
      cfg_q    <= 1'b0;
      cid_q    <= '0;
      crate_q  <= RATE_W'(1);
    end else begin
      in_pkt_q <= in_pkt_d;
      idx_q    <= idx_d;
      typ_q    <= typ_d;
      id_q     <= id_d;
      rraw_q   <= rraw_d;
      shadow_q <= shadow_d;
      ping_q   <= ping_d;
      set_q    <= set_d;
      cfg_q    <= cfg_d;
      cid_q    <= cid_d;
      crate_q  <= crate_d;
    end
  end

  assign ping_req = ping_q;
  assign set_req  = set_q;
  assign cfg_req  = cfg_q;
  assign cmd_id   = cid_q;
  assign cmd_rate = crate_q;
  assign payload  = shadow_q;

  // R9 R10: at most one command decoded per packet end
  a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ping_q, set_q, cfg_q}));

endmodule

// File: rtl/report_rate_timer.sv
module report_rate_timer
  import host_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  localparam int unsigned AW = $clog2(CLK_HZ + RATE_MAX + 1) + 1;

  logic [AW-1:0] acc_q, acc_d, sum;
  logic          tick_q, tick_d;

  always_comb begin
    sum    = acc_q + AW'(rate);
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (restart || !run) begin
      acc_d = '0;
    end else if (sum >= AW'(CLK_HZ)) begin
      acc_d  = sum - AW'(CLK_HZ);
      tick_d = 1'b1;
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R6: the timer only runs with a rate inside 1..64
  a_r6_rate_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rate >= RATE_W'(1) && rate <= RATE_W'(RATE_MAX)));

endmodule

// File: rtl/reply_framer.sv
module reply_framer
  import host_cmd_pkg::*;
#(
  parameter int unsigned IN_BYTES    = 4,
  parameter int unsigned FRAME_BYTES = 8,
  parameter logic [47:0] STATION_MAC = 48'h02_00_00_00_00_01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ping_req,
  input  logic                  rep_req,
  input  logic [7:0]            board_id,
  input  logic [IN_BYTES*8-1:0] snap,
  output logic                  out_valid,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [7:0]            out_data
);

  localparam int unsigned REP_LEN = 2 + IN_BYTES;
  localparam int unsigned LW      = $clog2(FRAME_BYTES + 1);

  logic                     busy_q, busy_d;
  logic [LW-1:0]            idx_q, idx_d, len_q, len_d;
  logic [FRAME_BYTES*8-1:0] sr_q, sr_d, ping_frame, rep_frame;
  logic                     ping_pend_q, ping_pend_d, rep_pend_q, rep_pend_d;
  logic                     want_ping, want_rep, take_ping, take_rep, last;

  always_comb begin
    ping_frame = '0;
    ping_frame[7:0]  = RT_PING;
    ping_frame[15:8] = board_id;
    for (int j = 0; j < 6; j++)
      ping_frame[(2+j)*8 +: 8] = STATION_MAC[47-8*j -: 8];

    rep_frame = '0;
    rep_frame[7:0]  = RT_DATA;
    rep_frame[15:8] = board_id;
    for (int k = 0; k < IN_BYTES; k++)
      rep_frame[(2+k)*8 +: 8] = snap[k*8 +: 8];
  end

  always_comb begin
    want_ping = ping_pend_q || ping_req;
    want_rep  = rep_pend_q || rep_req;
    last      = (idx_q == len_q - LW'(1));
    busy_d    = busy_q;
    idx_d     = idx_q;
    len_d     = len_q;
    sr_d      = sr_q;
    take_ping = 1'b0;
    take_rep  = 1'b0;
    if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + LW'(1);
        sr_d  = sr_q >> 8;
      end
    end else if (want_ping) begin
      take_ping = 1'b1;
      busy_d    = 1'b1;
      idx_d     = '0;
      len_d     = LW'(PING_LEN);
      sr_d      = ping_frame;
    end else if (want_rep) begin
      take_rep = 1'b1;
      busy_d   = 1'b1;
      idx_d    = '0;
      len_d    = LW'(REP_LEN);
      sr_d     = rep_frame;
    end
    ping_pend_d = want_ping && !take_ping;
    rep_pend_d  = want_rep && !take_rep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      idx_q       <= '0;
      len_q       <= LW'(PING_LEN);
      sr_q        <= '0;
      ping_pend_q <= 1'b0;
      rep_pend_q  <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      idx_q       <= idx_d;
      len_q       <= len_d;
      sr_q        <= sr_d;
      ping_pend_q <= ping_pend_d;
      rep_pend_q  <= rep_pend_d;
    end
  end

  assign out_valid = busy_q;
  assign out_sop   = busy_q && (idx_q == '0);
  assign out_eop   = busy_q && last;
  assign out_data  = sr_q[7:0];

  // R8: a frame in progress continues, with no fresh start marker
  a_r8_no_break: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |=> (out_valid && !out_sop));

  // R8: a report falling due during another reply is remembered
  a_r8_report_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_req && busy_q) |=> rep_pend_q);

endmodule

// File: rtl/host_cmd_handler.sv
module host_cmd_handler
  import host_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned IN_BYTES    = 4,
  parameter int unsigned OUT_BYTES   = 4,
  parameter logic [47:0] STATION_MAC = 48'h02_00_00_00_00_01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [7:0]             in_data,
  input  logic [IN_BYTES*8-1:0]  in_snap,
  output logic                   out_valid,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic [7:0]             out_data,
  output logic [OUT_BYTES*8-1:0] out_vals,
  output logic                   upd_strobe
);

  localparam int unsigned REP_LEN     = 2 + IN_BYTES;
  localparam int unsigned FRAME_BYTES = (REP_LEN > PING_LEN) ? REP_LEN : PING_LEN;

  logic [1:0]             rst_sync_q;
  logic                   rst_i_n;
  logic                   ping_req, set_req, cfg_req, tick;
  logic [7:0]             cmd_id;
  logic [RATE_W-1:0]      cmd_rate;
  logic [OUT_BYTES*8-1:0] payload;

  logic [7:0]             id_q, id_d;
  logic [OUT_BYTES*8-1:0] vals_q, vals_d;
  logic                   strobe_q, strobe_d, run_q, run_d;
  logic [RATE_W-1:0]      rate_q, rate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  cmd_rx_parse #(.OUT_BYTES(OUT_BYTES)) u_parse (
    .clk(clk), .rst_n(rst_i_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .ping_req(ping_req), .set_req(set_req), .cfg_req(cfg_req),
    .cmd_id(cmd_id), .cmd_rate(cmd_rate), .payload(payload)
  );

  always_comb begin
    id_d     = set_req ? cmd_id : id_q;
    vals_d   = cfg_req ? payload : vals_q;
    strobe_d = cfg_req;
    run_d    = run_q || cfg_req;
    rate_d   = cfg_req ? cmd_rate : rate_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      id_q     <= '0;
      vals_q   <= '0;
      strobe_q <= 1'b0;
      run_q    <= 1'b0;
      rate_q   <= RATE_W'(1);
    end else begin
      id_q     <= id_d;
      vals_q   <= vals_d;
      strobe_q <= strobe_d;
      run_q    <= run_d;
      rate_q   <= rate_d;
    end
  end

  report_rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_i_n),
    .restart(cfg_req), .run(run_q), .rate(rate_q), .tick(tick)
  );

  reply_framer #(
    .IN_BYTES(IN_BYTES), .FRAME_BYTES(FRAME_BYTES), .STATION_MAC(STATION_MAC)
  ) u_tx (
    .clk(clk), .rst_n(rst_i_n),
    .ping_req(ping_req), .rep_req(tick), .board_id(id_q), .snap(in_snap),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  assign out_vals   = vals_q;
  assign upd_strobe = strobe_q;

  // R3: the identifier moves only on a decoded set-identifier command
  a_r3_id_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    !set_req |=> $stable(id_q));

  // R4: output values change only in a strobe cycle
  a_r4_vals_with_strobe: assert property (@(posedge clk) disable iff (!rst_i_n)
    !upd_strobe |-> $stable(out_vals));

  // R7: no report tick right after a restart
  a_r7_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_req |=> !tick);

endmodule

// File: tb/host_cmd_handler_test.sv
module host_cmd_handler_test;

  localparam int unsigned CLK_HZ = 6400;
  localparam logic [47:0] MAC    = 48'h02_1A_2B_3C_4D_5E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [31:0] in_snap = 32'hDDCCBBAA;
  logic        out_valid, out_sop, out_eop, upd_strobe;
  logic [7:0]  out_data;
  logic [31:0] out_vals;

  always #2 clk = ~clk;

  host_cmd_handler #(
    .CLK_HZ(CLK_HZ), .IN_BYTES(4), .OUT_BYTES(4), .STATION_MAC(MAC)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_snap(in_snap),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .out_vals(out_vals), .upd_strobe(upd_strobe)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // frame monitor
  logic [7:0] fbuf [0:15];
  logic [7:0] ping_buf [0:15];
  logic [7:0] rep_buf [0:15];
  int fidx = 0, ping_len = 0, rep_len = 0;
  int ping_cnt = 0, rep_cnt = 0, strobe_cnt = 0;
  int cur_sop = 0, ping_sop = 0, ping_eop = 0, rep_sop = 0, rep_prev = 0;
  bit in_frame = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_strobe) strobe_cnt++;
      if (out_valid) begin
        if (out_sop) begin
          if (in_frame) check(0, "R8 start inside frame", 1, 0);
          in_frame = 1; fidx = 0; cur_sop = cyc;
        end else if (!in_frame) check(0, "R8 byte outside frame", 1, 0);
        if (fidx < 16) fbuf[fidx] = out_data;
        fidx++;
        if (out_eop) begin
          in_frame = 0;
          if (fbuf[0] == 8'h00) begin
            for (int i = 0; i < 16; i++) ping_buf[i] = fbuf[i];
            ping_len = fidx; ping_sop = cur_sop; ping_eop = cyc; ping_cnt++;
          end else begin
            for (int i = 0; i < 16; i++) rep_buf[i] = fbuf[i];
            rep_len = fidx; rep_prev = rep_sop; rep_sop = cur_sop; rep_cnt++;
          end
        end
      end else if (in_frame) check(0, "R8 gap inside frame", 1, 0);
    end
  end

  logic [7:0] pkt [0:15];
  int last_eop_cyc = 0;

  task automatic send(input int n, input bit with_sop);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_sop   = with_sop && (i == 0);
      in_eop   = (i == n - 1);
      in_data  = pkt[i];
      @(negedge clk);
      if (i == n - 1) last_eop_cyc = cyc;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic wait_ping(input int start);
    for (int t = 0; t < 100 && ping_cnt == start; t++) @(negedge clk);
    check(ping_cnt != start, "R2 ping reply arrives", ping_cnt, start + 1);
  endtask

  task automatic wait_rep(input int start, input int limit);
    for (int t = 0; t < limit && rep_cnt == start; t++) @(negedge clk);
    check(rep_cnt != start, "R5 report arrives", rep_cnt, start + 1);
  endtask

  task automatic ping_expect_id(input logic [7:0] id, input string req);
    int s = ping_cnt;
    pkt[0] = 8'h00;
    send(1, 1);
    wait_ping(s);
    check(ping_len == 8, "R2 ping length", ping_len, 8);
    check(ping_buf[1] == id, req, ping_buf[1], id);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R1 no reply after reset", out_valid, 0);
    check(upd_strobe == 1'b0, "R1 strobe low", upd_strobe, 0);
    check(out_vals == 32'h0, "R1 outputs zero", out_vals, 0);
    repeat (300) @(negedge clk);
    check(rep_cnt == 0, "R1 no reports before config", rep_cnt, 0);
  endtask

  task automatic t_ping;
    ping_expect_id(8'h00, "R1 id zero before assignment");
    check(ping_buf[0] == 8'h00, "R2 reply type", ping_buf[0], 0);
    for (int j = 0; j < 6; j++)
      check(ping_buf[2+j] == MAC[47-8*j -: 8], "R2 mac byte", ping_buf[2+j], MAC[47-8*j -: 8]);
  endtask

  task automatic t_setid;
    int s = ping_cnt;
    pkt[0] = 8'h01; pkt[1] = 8'h5A;
    send(2, 1);
    repeat (30) @(negedge clk);
    check(ping_cnt == s && rep_cnt == 0, "R3 no reply to set id", ping_cnt, s);
    ping_expect_id(8'h5A, "R3 id assigned");
  endtask

  task automatic t_short;
    int st = strobe_cnt;
    pkt[0] = 8'h01;
    send(1, 1);
    ping_expect_id(8'h5A, "R10 short set id dropped");
    pkt[0] = 8'h02; pkt[1] = 8'h00;
    send(2, 1);
    repeat (300) @(negedge clk);
    check(strobe_cnt == st, "R10 short config no strobe", strobe_cnt, st);
    check(rep_cnt == 0, "R10 short config no reports", rep_cnt, 0);
    pkt[0] = 8'h01; pkt[1] = 8'h77;
    send(2, 0);
    ping_expect_id(8'h5A, "R10 bytes without start ignored");
  endtask

  task automatic t_unknown;
    int s = ping_cnt, st = strobe_cnt;
    pkt[0] = 8'h07; pkt[1] = 8'h33; pkt[2] = 8'h05; pkt[3] = 8'h09;
    send(4, 1);
    repeat (300) @(negedge clk);
    check(ping_cnt == s && rep_cnt == 0, "R9 no reply to unknown type", ping_cnt, s);
    check(strobe_cnt == st, "R9 no strobe on unknown type", strobe_cnt, st);
    ping_expect_id(8'h5A, "R9 id unchanged by unknown type");
  endtask

  task automatic t_config;
    int st = strobe_cnt, r;
    pkt[0] = 8'h02; pkt[1] = 8'h11; pkt[2] = 8'd64;
    pkt[3] = 8'hA1; pkt[4] = 8'hB2; pkt[5] = 8'hC3;
    send(6, 1);
    repeat (3) @(negedge clk);
    check(strobe_cnt == st + 1, "R4 one strobe", strobe_cnt, st + 1);
    check(out_vals == 32'h00C3B2A1, "R4 partial payload", out_vals, 32'h00C3B2A1);
    r = rep_cnt;
    wait_rep(r, 400);
    check(rep_sop - last_eop_cyc == 102, "R7 first report offset rate 64", rep_sop - last_eop_cyc, 102);
    check(rep_len == 6, "R5 report length", rep_len, 6);
    check({rep_buf[0], rep_buf[1]} == 16'h015A, "R5 report header", {rep_buf[0], rep_buf[1]}, 16'h015A);
    check({rep_buf[5], rep_buf[4], rep_buf[3], rep_buf[2]} == in_snap, "R5 snapshot bytes",
          {rep_buf[5], rep_buf[4], rep_buf[3], rep_buf[2]}, in_snap);
    in_snap = 32'h44332211;
    wait_rep(rep_cnt, 400);
    check(rep_sop - rep_prev == 100, "R5 period at 64 Hz", rep_sop - rep_prev, 100);
    check({rep_buf[5], rep_buf[4], rep_buf[3], rep_buf[2]} == 32'h44332211, "R5 new snapshot",
          {rep_buf[5], rep_buf[4], rep_buf[3], rep_buf[2]}, 32'h44332211);
  endtask

  task automatic t_restart;
    int r;
    wait_rep(rep_cnt, 400);
    pkt[0] = 8'h02; pkt[1] = 8'h00; pkt[2] = 8'd32;
    for (int i = 0; i < 6; i++) pkt[3+i] = 8'(i + 1);
    send(9, 1);
    repeat (3) @(negedge clk);
    check(out_vals == 32'h04030201, "R4 extra payload ignored", out_vals, 32'h04030201);
    r = rep_cnt;
    wait_rep(r, 600);
    check(rep_sop - last_eop_cyc == 202, "R7 restart offset rate 32", rep_sop - last_eop_cyc, 202);
    wait_rep(rep_cnt, 600);
    check(rep_sop - rep_prev == 200, "R5 period at 32 Hz", rep_sop - rep_prev, 200);
  endtask

  task automatic t_clamp;
    logic [31:0] keep = out_vals;
    int st;
    wait_rep(rep_cnt, 600);
    st = strobe_cnt;
    pkt[0] = 8'h02; pkt[1] = 8'h00; pkt[2] = 8'd200;
    send(3, 1);
    repeat (3) @(negedge clk);
    check(strobe_cnt == st + 1 && out_vals == keep, "R4 no payload keeps values", out_vals, keep);
    wait_rep(rep_cnt, 400);
    check(rep_sop - last_eop_cyc == 102, "R6 rate above 64 clamped", rep_sop - last_eop_cyc, 102);
    pkt[0] = 8'h02; pkt[1] = 8'h00; pkt[2] = 8'd0;
    send(3, 1);
    wait_rep(rep_cnt, 7000);
    check(rep_sop - last_eop_cyc == 6402, "R6 rate zero clamped to 1 Hz", rep_sop - last_eop_cyc, 6402);
  endtask

  task automatic t_collision;
    int t, s, r;
    wait_rep(rep_cnt, 7000);
    pkt[0] = 8'h02; pkt[1] = 8'h00; pkt[2] = 8'd64;
    send(3, 1);
    wait_rep(rep_cnt, 400);
    t = rep_sop;
    while (cyc < t + 94) @(negedge clk);
    s = ping_cnt; r = rep_cnt;
    pkt[0] = 8'h00;
    send(1, 1);
    wait_ping(s);
    check(ping_eop >= t + 100 && ping_sop < t + 100, "R8 ping covers report due point", ping_eop, t + 100);
    check(ping_len == 8 && ping_buf[2] == MAC[47:40], "R8 ping intact", ping_len, 8);
    wait_rep(r, 200);
    check(rep_sop > ping_eop && rep_sop <= ping_eop + 2, "R8 held report follows ping", rep_sop, ping_eop + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_ping;
    t_setid;
    t_short;
    t_unknown;
    t_config;
    t_restart;
    t_clamp;
    t_collision;
    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule